// File: doc/BRIEF.md
# SD Card Clock Divider

This block derives the SD card clock from a fast core clock. All of its logic runs on the core clock. It produces a registered card-clock level and two one-cycle strobes. One strobe marks each rising card-clock edge and the other marks each falling edge. The command and data serialisers use these strobes to know when to shift or sample.

The division ratio comes from an 11-bit divider field. The ratio is always the field value plus two, so the output cannot be stopped. The largest field value gives the slowest clock, a ratio of 2049.

A data transfer can switch the block into a fast data mode. This happens while a transfer is active and the slow-card control is clear. In data mode only the low three bits of the field count, which gives ratios from 2 to 9. When the slow-card control is set, the full field is used at all times.

A new ratio is taken up only when the current card-clock period ends. Every period is therefore completed with the ratio that started it.

Top module: `sdclk_divider`

## Requirements
- R1: While reset is asserted, `card_clk`, `clk_rise` and `clk_fall` are all 0. In the first core cycle after reset is released, `card_clk` is 1 and `clk_rise` is 1.
- R2: With `data_active` = 0, each card-clock period lasts `div_val` + 2 core cycles, measured from one rising edge to the next.
- R3: Within a period of N core cycles, `card_clk` is high for floor(N/2) cycles, starting at the rising edge, and low for the remaining ceil(N/2) cycles.
- R4: With `data_active` = 1 and `slow_card` = 0, the period is `div_val[2:0]` + 2 core cycles, and bits 10:3 of `div_val` are ignored.
- R5: With `slow_card` = 1, the period is `div_val` + 2 core cycles whatever the value of `data_active`.
- R6: The ratio is sampled only in the last core cycle of a period. A change to `div_val`, `slow_card` or `data_active` at any other time leaves the current period's length and duty unchanged. A change applied in the last cycle of a period governs the very next period.
- R7: `clk_rise` is 1 exactly in the cycles where `card_clk` goes from 0 to 1. `clk_fall` is 1 exactly in the cycles where `card_clk` goes from 1 to 0. The two strobes are never 1 together, and there is one of each per period.
- R8: A `div_val` of 0x7FF gives a period of 2049 core cycles with 1024 high cycles, and the clock keeps running period after period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_val | input | 11 | Divider field; the ratio is this value plus two |
| slow_card | input | 1 | 1 forces the full divider even during transfers |
| data_active | input | 1 | 1 while a data transfer is in progress |
| card_clk | output | 1 | Card clock level, registered |
| clk_rise | output | 1 | One-cycle strobe in the cycle `card_clk` rises |
| clk_fall | output | 1 | One-cycle strobe in the cycle `card_clk` falls |

## Verification
Two events can fall in the same core cycle: the end of a period, which reloads the ratio, and a change of the divider or mode inputs.

The bench provokes this collision in two ways. It changes `div_val` in the exact last cycle of a period, which must give the new length at once. It also changes `div_val` a few cycles into a period, which must leave that period untouched.

A cycle-by-cycle reference model, holding only a position and a period length, judges every cycle. Separate interval counts between rising strobes confirm the period and high time for each case.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

  typedef enum logic {
    MODE_IDENT = 1'b0,
    MODE_DATA  = 1'b1
  } clk_mode_e;

  // Fast data mode applies only while a transfer runs and slow mode is off.
  function automatic clk_mode_e pick_mode(input logic slow, input logic active);
    return (active && !slow) ? MODE_DATA : MODE_IDENT;
  endfunction

endpackage

// File: rtl/sdclk_ratio_sel.sv
module sdclk_ratio_sel
  import sdclk_pkg::*;
#(
  parameter int DIV_W     = 11,
  parameter int DATA_BITS = 3,
  localparam int RW       = DIV_W + 1
) (
  input  logic [DIV_W-1:0] div_val,
  input  logic             slow_card,
  input  logic             data_active,
  output clk_mode_e        mode,
  output logic [RW-1:0]    ratio
);

  logic [RW-1:0] full_ratio;
  logic [RW-1:0] data_ratio;

  assign full_ratio = RW'(div_val) + RW'(2);

  generate
    if (DATA_BITS < DIV_W) begin : g_narrow
      assign data_ratio = RW'(div_val[DATA_BITS-1:0]) + RW'(2);
    end else begin : g_full
      assign data_ratio = full_ratio;
    end
  endgenerate

  assign mode  = pick_mode(slow_card, data_active);
  assign ratio = (mode == MODE_DATA) ? data_ratio : full_ratio;

endmodule

// File: rtl/sdclk_phase_ctr.sv
module sdclk_phase_ctr #(
  parameter int RW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] ratio_in,
  output logic [RW-1:0] cnt_nx,
  output logic [RW-1:0] ratio_nx,
  output logic          boundary
);

  logic [RW-1:0] cnt_q;
  logic [RW-1:0] ratio_q;

  assign boundary = (cnt_q == ratio_q - RW'(1));
  assign cnt_nx   = boundary ? '0 : cnt_q + RW'(1);
  assign ratio_nx = boundary ? ratio_in : ratio_q;

  // Reset parks the counter in the last cycle of a minimal period, so the
  // first edge after release is a rising one.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= RW'(1);
      ratio_q <= RW'(2);
    end else begin
      cnt_q   <= cnt_nx;
      ratio_q <= ratio_nx;
    end
  end

  // R6
  ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(ratio_q));

  // R2
  ratio_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_q >= RW'(2));

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < ratio_q);

endmodule

// File: rtl/sdclk_edge_gen.sv
module sdclk_edge_gen #(
  parameter int RW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] cnt_nx,
  input  logic [RW-1:0] ratio_nx,
  output logic          card_clk,
  output logic          clk_rise,
  output logic          clk_fall
);

  function automatic logic [RW-1:0] high_len(input logic [RW-1:0] r);
    return r >> 1;
  endfunction

  logic [RW-1:0] hl;
  assign hl = high_len(ratio_nx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      card_clk <= 1'b0;
      clk_rise <= 1'b0;
      clk_fall <= 1'b0;
    end else begin
      card_clk <= (cnt_nx < hl);
      clk_rise <= (cnt_nx == '0);
      clk_fall <= (cnt_nx == hl);
    end
  end

  // R7
  rise_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_rise |-> (card_clk && !$past(card_clk)));

  // R7
  fall_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_fall |-> (!card_clk && $past(card_clk)));

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(clk_rise && clk_fall));

  // R7
  toggle_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (card_clk != $past(card_clk)) |-> (clk_rise || clk_fall));

endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider
  import sdclk_pkg::*;
#(
  parameter int DIV_W     = 11,
  parameter int DATA_BITS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_val,
  input  logic             slow_card,
  input  logic             data_active,
  output logic             card_clk,
  output logic             clk_rise,
  output logic             clk_fall
);

  localparam int RW = DIV_W + 1;
  localparam int DATA_MAX_RATIO = (1 << DATA_BITS) + 1;

  clk_mode_e     mode;
  logic [RW-1:0] sel_ratio;
  logic [RW-1:0] cnt_nx;
  logic [RW-1:0] ratio_nx;
  logic          boundary;

  sdclk_ratio_sel #(.DIV_W(DIV_W), .DATA_BITS(DATA_BITS)) u_sel (
    .div_val    (div_val),
    .slow_card  (slow_card),
    .data_active(data_active),
    .mode       (mode),
    .ratio      (sel_ratio)
  );

  sdclk_phase_ctr #(.RW(RW)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .ratio_in(sel_ratio),
    .cnt_nx  (cnt_nx),
    .ratio_nx(ratio_nx),
    .boundary(boundary)
  );

  sdclk_edge_gen #(.RW(RW)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_nx  (cnt_nx),
    .ratio_nx(ratio_nx),
    .card_clk(card_clk),
    .clk_rise(clk_rise),
    .clk_fall(clk_fall)
  );

  // R4
  data_ratio_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_DATA) |-> (sel_ratio <= RW'(DATA_MAX_RATIO)));

  // R1
  boundary_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> clk_rise);

endmodule

// File: tb/sim_sdclk_divider.sv
module sim_sdclk_divider;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] div_val = '0;
  logic        slow_card = 1'b0;
  logic        data_active = 1'b0;
  logic        card_clk, clk_rise, clk_fall;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  sdclk_divider u0 (
    .clk(clk), .rst_n(rst_n), .div_val(div_val), .slow_card(slow_card),
    .data_active(data_active), .card_clk(card_clk), .clk_rise(clk_rise),
    .clk_fall(clk_fall)
  );

  // Behavioural reference: a position inside a period of a given length.
  int pos = 1, per = 2;
  bit e_clk = 0, e_rise = 0, e_fall = 0;

  function automatic int wanted_period(int d, bit slow, bit act);
    if (act && !slow) return (d % 8) + 2;
    return d + 2;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos = 1; per = 2; e_clk = 0; e_rise = 0; e_fall = 0;
    end else begin
      if (pos + 1 >= per) begin
        pos = 0;
        per = wanted_period(int'(div_val), slow_card, data_active);
      end else begin
        pos = pos + 1;
      end
      e_clk  = (pos < per / 2);
      e_rise = (pos == 0);
      e_fall = (pos == per / 2);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Per-cycle model comparison (R3, R6, R7).
  always @(negedge clk) begin
    if (rst_n) begin
      chk(card_clk == e_clk, "R3 card_clk vs model", card_clk, e_clk);
      chk(clk_rise == e_rise, "R7 rise strobe vs model", clk_rise, e_rise);
      chk(clk_fall == e_fall, "R7 fall strobe vs model", clk_fall, e_fall);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 190000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic wait_rise();
    do @(negedge clk); while (!clk_rise);
  endtask

  // Called at the negedge showing a rise; ends at the next rise.
  task automatic measure(input int exp_n, input int exp_hi, input string tag);
    int n = 1;
    int hi = int'(card_clk);
    int falls = 0;
    forever begin
      @(negedge clk);
      if (clk_rise) break;
      n++;
      hi += int'(card_clk);
      falls += int'(clk_fall);
    end
    chk(n == exp_n, {tag, " period"}, n, exp_n);
    chk(hi == exp_hi, {tag, " high time"}, hi, exp_hi);
    chk(falls == 1, "R7 one fall per period", falls, 1);
  endtask

  task automatic run_cfg(input int d, input bit s, input bit a,
                         input int exp_n, input string tag);
    div_val = 11'(d); slow_card = s; data_active = a;
    wait_rise();
    measure(exp_n, exp_n / 2, tag);
  endtask

  initial begin
    repeat (4) begin
      @(negedge clk);
      chk(!card_clk && !clk_rise && !clk_fall, "R1 reset outputs low",
          {card_clk, clk_rise, clk_fall}, 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk(card_clk && clk_rise, "R1 first rise after release",
        {card_clk, clk_rise}, 3);
    measure(2, 1, "R2 div0");

    run_cfg(1, 0, 0, 3, "R2 div1");
    run_cfg(6, 0, 0, 8, "R2 div6");
    run_cfg(5, 0, 0, 7, "R3 odd ratio");
    run_cfg(13, 0, 1, 7, "R4 data mode low bits");
    run_cfg(11'h7ff, 0, 1, 9, "R4 data mode max");
    run_cfg(13, 1, 1, 15, "R5 slow card in transfer");
    run_cfg(13, 1, 0, 15, "R5 slow card idle");
    run_cfg(11'h7ff, 0, 0, 2049, "R8 max divider");
    measure(2049, 1024, "R8 keeps running");

    // R6: change mid-period has no effect on the running period.
    div_val = 11'd9;
    wait_rise();
    begin
      int n = 1;
      repeat (3) begin @(negedge clk); n++; end
      div_val = 11'd1;
      forever begin
        @(negedge clk);
        if (clk_rise) break;
        n++;
      end
      chk(n == 11, "R6 mid-period change ignored", n, 11);
    end
    measure(3, 1, "R6 new ratio next period");

    // R6: change exactly in the last cycle of a period.
    div_val = 11'd3;
    wait_rise();
    measure(5, 2, "R6 ratio 5 setup");
    repeat (4) @(negedge clk);
    div_val = 11'd2;
    wait_rise();
    measure(4, 2, "R6 boundary change");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule